// File: doc/BRIEF.md
# Read-modify-write instruction sequencer

This block steps an 8-bit processor through its single-operand read-modify-write instructions. These are increment, decrement, shift left, shift right, rotate left and rotate right. The surrounding core has already fetched the opcode. It presents the opcode with `start`, together with the address of the byte that follows the opcode. The sequencer then runs the bus one cycle at a time: it fetches any operand bytes, forms the effective address, reads the target byte and writes the modified byte back to the same address.

The target can be the A, X or Y register, a byte on the direct page, a direct-page byte indexed by X, or a full 16-bit absolute address. `page_sel` picks which 256-byte page is the direct page. Register targets use no bus traffic. Instead, the result leaves on a register write port for one cycle. Every instruction ends with a one-cycle `done`. In that cycle the new N, Z and C flags are presented. An opcode outside the supported set raises `illegal` for one cycle and starts nothing.

The bus is synchronous. `bus_rdata` must be valid in the same cycle as `bus_rd`, and it is captured at the clock edge that ends that cycle.

Top module: `rmw_seq`

## Requirements
- R1: After reset the sequencer is idle. `busy`, `done`, `illegal`, `bus_rd`, `bus_wr`, `reg_wr` and `flag_wr` are all low.
- R2: The register-target opcodes are 0xBC, 0x9C, 0x1C, 0x5C, 0x3C and 0x7C on A, 0x3D and 0x1D on X, and 0xFC and 0xDC on Y. Each takes exactly one busy cycle after the start cycle. That cycle has no bus strobe and raises `reg_wr` and `done`. The result is on `reg_wdata`, and `reg_dst` is 0 for A, 1 for X and 2 for Y.
- R3: The direct-page opcodes are 0xAB, 0x8B, 0x0B, 0x4B, 0x2B and 0x6B. Each takes three cycles. The first reads the offset at `op_pc`. The second reads address {7'b0, page_sel, offset}. The third writes the result to that same address with `done`.
- R4: The indexed direct-page opcodes are 0xBB, 0x9B, 0x1B, 0x5B, 0x3B and 0x7B. Each takes four cycles: read the offset at `op_pc`, one cycle with no strobe, read at {7'b0, page_sel, offset+X}, then write there with `done`. The sum offset+X wraps within 8 bits.
- R5: The absolute opcodes are 0xAC, 0x8C, 0x0C, 0x4C, 0x2C and 0x6C. Each takes four cycles: read the low byte at `op_pc`, read the high byte at `op_pc`+1, read at {high, low}, then write there with `done`.
- R6: Increment and decrement (the opcodes in each group whose high nibble is 0xA/0xB or 0x8/0x9, plus 0x3D, 0xFC, 0x1D and 0xDC) produce value±1 modulo 256. N is bit 7 of the result, Z is set when the result is zero, and C is passed through unchanged from `c_val`.
- R7: Shift left (high nibble 0x0/0x1) gives C = old bit 7 and result = value<<1 with bit 0 cleared. Shift right (high nibble 0x4/0x5) gives C = old bit 0 and result = value>>1 with bit 7 cleared. N and Z follow the result.
- R8: Rotate left (high nibble 0x2/0x3) shifts `c_val` into bit 0 and old bit 7 into C. Rotate right (high nibble 0x6/0x7) shifts `c_val` into bit 7 and old bit 0 into C. N and Z follow the result.
- R9: An unsupported opcode presented with `start` while idle pulses `illegal` for the following cycle. It causes no bus strobe, and the sequencer stays idle.
- R10: `busy` falls in the cycle after `done`. `start` is ignored while `busy` is high, and no further busy cycles follow the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opcode valid; accepted only while idle |
| opcode | input | 8 | Fetched opcode |
| op_pc | input | 16 | Address of the byte after the opcode |
| page_sel | input | 1 | Direct-page select (page 0x00 or 0x01) |
| a_val | input | 8 | Current A register |
| x_val | input | 8 | Current X register |
| y_val | input | 8 | Current Y register |
| c_val | input | 1 | Current carry flag |
| bus_rdata | input | 8 | Read data, valid in the strobe cycle |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| reg_wr | output | 1 | Register write pulse |
| reg_dst | output | 2 | Register selector: 0 A, 1 X, 2 Y |
| reg_wdata | output | 8 | Register write data |
| flag_wr | output | 1 | Flag update pulse |
| flag_n | output | 1 | New N flag |
| flag_z | output | 1 | New Z flag |
| flag_c | output | 1 | New C flag |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of an instruction |
| illegal | output | 1 | Unsupported opcode pulse |

## Verification
The bench drives an indexed access whose offset plus X overflows 8 bits. A design that carried into the page bit would read from the wrong page. Rotates are run with carry both set and clear, and increments are run with carry set. This exposes a rotate that ignores carry, or an increment that clears C. The bench holds `start` high with a legal opcode through a whole instruction: a design that restarted or stretched its sequence would show extra busy cycles. It also checks the absolute form's byte order and the idle cycle of the indexed form, which a swapped or missing step would break.

// File: rtl/rmw_seq.sv
`timescale 1ns/1ps
module rmw_seq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] opcode,
  input  logic [2*DW-1:0] op_pc,
  input  logic          page_sel,
  input  logic [DW-1:0] a_val,
  input  logic [DW-1:0] x_val,
  input  logic [DW-1:0] y_val,
  input  logic          c_val,
  input  logic [DW-1:0] bus_rdata,
  output logic [2*DW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  output logic          reg_wr,
  output logic [1:0]    reg_dst,
  output logic [DW-1:0] reg_wdata,
  output logic          flag_wr,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_c,
  output logic          busy,
  output logic          done,
  output logic          illegal
);
  localparam int AW = 2 * DW;
  localparam logic [1:0] M_REG = 2'd0, M_DP = 2'd1, M_DPX = 2'd2, M_ABS = 2'd3;
  localparam logic [2:0] F_INC = 3'd0, F_DEC = 3'd1, F_SHL = 3'd2,
                         F_SHR = 3'd3, F_ROL = 3'd4, F_ROR = 3'd5;
  localparam logic [1:0] T_A = 2'd0, T_X = 2'd1, T_Y = 2'd2;
  localparam logic [DW-1:0] ONE = 1;
  localparam logic [AW-1:0] ONE_W = 1;

  function automatic logic [7:0] decode(input logic [DW-1:0] o);
    case (o)
      8'hBC: decode = {1'b1, M_REG, F_INC, T_A};
      8'h3D: decode = {1'b1, M_REG, F_INC, T_X};
      8'hFC: decode = {1'b1, M_REG, F_INC, T_Y};
      8'h9C: decode = {1'b1, M_REG, F_DEC, T_A};
      8'h1D: decode = {1'b1, M_REG, F_DEC, T_X};
      8'hDC: decode = {1'b1, M_REG, F_DEC, T_Y};
      8'h1C: decode = {1'b1, M_REG, F_SHL, T_A};
      8'h5C: decode = {1'b1, M_REG, F_SHR, T_A};
      8'h3C: decode = {1'b1, M_REG, F_ROL, T_A};
      8'h7C: decode = {1'b1, M_REG, F_ROR, T_A};
      8'hAB: decode = {1'b1, M_DP,  F_INC, T_A};
      8'h8B: decode = {1'b1, M_DP,  F_DEC, T_A};
      8'h0B: decode = {1'b1, M_DP,  F_SHL, T_A};
      8'h4B: decode = {1'b1, M_DP,  F_SHR, T_A};
      8'h2B: decode = {1'b1, M_DP,  F_ROL, T_A};
      8'h6B: decode = {1'b1, M_DP,  F_ROR, T_A};
      8'hBB: decode = {1'b1, M_DPX, F_INC, T_A};
      8'h9B: decode = {1'b1, M_DPX, F_DEC, T_A};
      8'h1B: decode = {1'b1, M_DPX, F_SHL, T_A};
      8'h5B: decode = {1'b1, M_DPX, F_SHR, T_A};
      8'h3B: decode = {1'b1, M_DPX, F_ROL, T_A};
      8'h7B: decode = {1'b1, M_DPX, F_ROR, T_A};
      8'hAC: decode = {1'b1, M_ABS, F_INC, T_A};
      8'h8C: decode = {1'b1, M_ABS, F_DEC, T_A};
      8'h0C: decode = {1'b1, M_ABS, F_SHL, T_A};
      8'h4C: decode = {1'b1, M_ABS, F_SHR, T_A};
      8'h2C: decode = {1'b1, M_ABS, F_ROL, T_A};
      8'h6C: decode = {1'b1, M_ABS, F_ROR, T_A};
      default: decode = 8'h00;
    endcase
  endfunction

  logic [2:0]    step;
  logic [6:0]    dq;
  logic [DW-1:0] lo, hi, opnd;
  logic [AW-1:0] pc;
  logic [7:0]    dnew;

  assign dnew = decode(opcode);

  wire [1:0] mode = dq[6:5];
  wire [2:0] fn   = dq[4:2];
  assign reg_dst  = dq[1:0];
  assign busy     = step != 3'd0;

  wire s1 = step == 3'd1;
  wire s2 = step == 3'd2;
  wire s3 = step == 3'd3;
  wire s4 = step == 3'd4;

  wire fetch_lo = s1 && mode != M_REG;
  wire fetch_hi = s2 && mode == M_ABS;
  wire rd_tgt   = (mode == M_DP && s2) || ((mode == M_DPX || mode == M_ABS) && s3);
  wire wr_tgt   = (mode == M_DP && s3) || ((mode == M_DPX || mode == M_ABS) && s4);
  wire reg_step = mode == M_REG && s1;

  assign done    = reg_step || wr_tgt;
  assign bus_rd  = fetch_lo || fetch_hi || rd_tgt;
  assign bus_wr  = wr_tgt;
  assign reg_wr  = reg_step;
  assign flag_wr = done;

  logic [DW-1:0] idx;
  logic [AW-1:0] tgt;
  assign idx = lo + x_val;

  always_comb begin
    case (mode)
      M_DP:    tgt = {{(AW-DW-1){1'b0}}, page_sel, lo};
      M_DPX:   tgt = {{(AW-DW-1){1'b0}}, page_sel, idx};
      M_ABS:   tgt = {hi, lo};
      default: tgt = '0;
    endcase
  end

  always_comb begin
    if (fetch_lo)                bus_addr = pc;
    else if (fetch_hi)           bus_addr = pc + ONE_W;
    else if (rd_tgt || wr_tgt)   bus_addr = tgt;
    else                         bus_addr = '0;
  end

  logic [DW-1:0] src, res;
  logic          cout;

  always_comb begin
    if (mode == M_REG) begin
      case (reg_dst)
        T_X:     src = x_val;
        T_Y:     src = y_val;
        default: src = a_val;
      endcase
    end else begin
      src = opnd;
    end
  end

  always_comb begin
    res  = src;
    cout = c_val;
    case (fn)
      F_INC: res = src + ONE;
      F_DEC: res = src - ONE;
      F_SHL: {cout, res} = {src, 1'b0};
      F_SHR: {res, cout} = {1'b0, src};
      F_ROL: {cout, res} = {src, c_val};
      F_ROR: {res, cout} = {c_val, src};
      default: ;
    endcase
  end

  assign bus_wdata = wr_tgt ? res : '0;
  assign reg_wdata = reg_step ? res : '0;
  assign flag_n    = done & res[DW-1];
  assign flag_z    = done & (res == '0);
  assign flag_c    = done & cout;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step    <= '0;
      dq      <= '0;
      pc      <= '0;
      lo      <= '0;
      hi      <= '0;
      opnd    <= '0;
      illegal <= 1'b0;
    end else begin
      illegal <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (dnew[7]) begin
            step <= 3'd1;
            dq   <= dnew[6:0];
            pc   <= op_pc;
          end else begin
            illegal <= 1'b1;
          end
        end
      end else begin
        step <= done ? 3'd0 : step + 3'd1;
        if (fetch_lo) lo   <= bus_rdata;
        if (fetch_hi) hi   <= bus_rdata;
        if (rd_tgt)   opnd <= bus_rdata;
      end
    end
  end

  // R3/R4/R5: a write goes to the address read in the cycle before
  p_wr_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> ($past(bus_rd) && bus_addr == $past(bus_addr)));

  p_no_rdwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  p_reg_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (!bus_rd && !bus_wr && done));

  p_illegal_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && !bus_rd && !bus_wr));

  p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_strobes_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr || reg_wr) |-> busy);
endmodule

// File: tb/test_rmw_seq.sv
`timescale 1ns/1ps
module test_rmw_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, page_sel = 1'b0, c_val = 1'b0;
  logic [7:0] opcode = '0, a_val = '0, x_val = '0, y_val = '0, bus_rdata = '0;
  logic [15:0] op_pc = '0;
  logic [15:0] bus_addr;
  logic bus_rd, bus_wr, reg_wr, flag_wr, flag_n, flag_z, flag_c, busy, done, illegal;
  logic [7:0] bus_wdata, reg_wdata;
  logic [1:0] reg_dst;

  rmw_seq i_rmw_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .op_pc(op_pc),
    .page_sel(page_sel), .a_val(a_val), .x_val(x_val), .y_val(y_val), .c_val(c_val),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .reg_wr(reg_wr), .reg_dst(reg_dst), .reg_wdata(reg_wdata),
    .flag_wr(flag_wr), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .busy(busy), .done(done), .illegal(illegal));

  always #10 clk = ~clk;

  localparam int K_INC = 0, K_DEC = 1, K_SHL = 2, K_SHR = 3, K_ROL = 4, K_ROR = 5;

  typedef struct {
    bit rd; bit wr; logic [15:0] addr; logic [7:0] wd; logic [7:0] rdv;
    bit rw; logic [1:0] dst; logic [7:0] rv;
    bit fl; bit n; bit z; bit c; bit dn; int req;
  } exp_t;

  exp_t q[$];
  exp_t plan[$];
  int nchk = 0, nfail = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] alu(int k, logic [7:0] v, logic cin);
    case (k)
      K_INC: alu = {cin, v + 8'd1};
      K_DEC: alu = {cin, v - 8'd1};
      K_SHL: alu = {v[7], v[6:0], 1'b0};
      K_SHR: alu = {v[0], 1'b0, v[7:1]};
      K_ROL: alu = {v[7], v[6:0], cin};
      default: alu = {v[0], cin, v[7:1]};
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (!busy && (bus_rd || bus_wr || reg_wr)) begin
        nchk++; nfail++;
        $display("FAIL R1 strobe while idle: actual=1 expected=0");
      end
      if (busy) begin
        if (q.size() == 0) begin
          nchk++; nfail++;
          $display("FAIL R10 unexpected busy cycle: actual=1 expected=0");
        end else begin
          exp_t e;
          string r;
          e = q.pop_front();
          r = $sformatf("R%0d", e.req);
          check(done == e.dn, r, "done", done, e.dn);
          check(bus_rd == e.rd, r, "bus_rd", bus_rd, e.rd);
          check(bus_wr == e.wr, r, "bus_wr", bus_wr, e.wr);
          if (e.rd || e.wr) check(bus_addr == e.addr, r, "bus_addr", bus_addr, e.addr);
          if (e.wr) check(bus_wdata == e.wd, r, "bus_wdata", bus_wdata, e.wd);
          check(reg_wr == e.rw, r, "reg_wr", reg_wr, e.rw);
          if (e.rw) begin
            check(reg_dst == e.dst, r, "reg_dst", reg_dst, e.dst);
            check(reg_wdata == e.rv, r, "reg_wdata", reg_wdata, e.rv);
          end
          check(flag_wr == e.fl, r, "flag_wr", flag_wr, e.fl);
          if (e.fl) begin
            check(flag_n == e.n, r, "flag_n", flag_n, e.n);
            check(flag_z == e.z, r, "flag_z", flag_z, e.z);
            check(flag_c == e.c, r, "flag_c", flag_c, e.c);
          end
        end
      end
    end
  end

  function automatic exp_t blank(int req);
    exp_t e;
    e = '{rd:0, wr:0, addr:0, wd:0, rdv:0, rw:0, dst:0, rv:0,
          fl:0, n:0, z:0, c:0, dn:0, req:req};
    return e;
  endfunction

  function automatic exp_t fin(exp_t e, logic [8:0] r);
    e.fl = 1; e.dn = 1; e.n = r[7]; e.z = (r[7:0] == 8'h00); e.c = r[8];
    return e;
  endfunction

  // driver: push plan into scoreboard and drive rdata per cycle
  task automatic exec(logic [7:0] op, logic [15:0] pc, bit hold);
    foreach (plan[i]) q.push_back(plan[i]);
    @(posedge clk); #1;
    start = 1; opcode = op; op_pc = pc;
    foreach (plan[i]) begin
      @(posedge clk); #1;
      start = hold; opcode = hold ? 8'hBC : 8'h00;
      bus_rdata = plan[i].rdv;
    end
    @(posedge clk); #1;
    start = 0; bus_rdata = 0;
    @(negedge clk);
    check(busy == 0 && q.size() == 0, "R10", "idle after done", busy, 0);
    plan.delete();
  endtask

  task automatic run_reg(logic [7:0] op, int k, logic [1:0] dst, logic [7:0] v, logic cin, int req);
    exp_t e;
    logic [8:0] r;
    a_val = 8'h11; x_val = 8'h22; y_val = 8'h33; c_val = cin;
    if (dst == 0) a_val = v; else if (dst == 1) x_val = v; else y_val = v;
    r = alu(k, v, cin);
    e = fin(blank(req), r);
    e.rw = 1; e.dst = dst; e.rv = r[7:0];
    plan.push_back(e);
    exec(op, 16'h0100, 0);
  endtask

  task automatic run_dp(logic [7:0] op, int k, logic pg, logic [7:0] off, logic [7:0] v,
                        logic cin, bit hold, int req);
    exp_t e;
    logic [8:0] r;
    logic [15:0] ad;
    page_sel = pg; c_val = cin; ad = {7'b0, pg, off};
    r = alu(k, v, cin);
    e = blank(req); e.rd = 1; e.addr = 16'h0420; e.rdv = off; plan.push_back(e);
    e = blank(req); e.rd = 1; e.addr = ad; e.rdv = v; plan.push_back(e);
    e = fin(blank(req), r); e.wr = 1; e.addr = ad; e.wd = r[7:0]; plan.push_back(e);
    exec(op, 16'h0420, hold);
  endtask

  task automatic run_dpx(logic [7:0] op, int k, logic pg, logic [7:0] off, logic [7:0] xv,
                         logic [7:0] v, logic cin, int req);
    exp_t e;
    logic [8:0] r;
    logic [7:0] s;
    page_sel = pg; c_val = cin; x_val = xv; s = off + xv;
    r = alu(k, v, cin);
    e = blank(req); e.rd = 1; e.addr = 16'h0C00; e.rdv = off; plan.push_back(e);
    e = blank(req); plan.push_back(e);
    e = blank(req); e.rd = 1; e.addr = {7'b0, pg, s}; e.rdv = v; plan.push_back(e);
    e = fin(blank(req), r); e.wr = 1; e.addr = {7'b0, pg, s}; e.wd = r[7:0]; plan.push_back(e);
    exec(op, 16'h0C00, 0);
  endtask

  task automatic run_abs(logic [7:0] op, int k, logic [15:0] pc, logic [15:0] ad,
                         logic [7:0] v, logic cin, int req);
    exp_t e;
    logic [8:0] r;
    c_val = cin;
    r = alu(k, v, cin);
    e = blank(req); e.rd = 1; e.addr = pc; e.rdv = ad[7:0]; plan.push_back(e);
    e = blank(req); e.rd = 1; e.addr = pc + 16'd1; e.rdv = ad[15:8]; plan.push_back(e);
    e = blank(req); e.rd = 1; e.addr = ad; e.rdv = v; plan.push_back(e);
    e = fin(blank(req), r); e.wr = 1; e.addr = ad; e.wd = r[7:0]; plan.push_back(e);
    exec(op, pc, 0);
  endtask

  task automatic run_bad(logic [7:0] op);
    @(posedge clk); #1; start = 1; opcode = op;
    @(posedge clk); #1; start = 0;
    @(negedge clk);
    check(illegal == 1, "R9", "illegal pulse", illegal, 1);
    check(busy == 0 && !bus_rd && !bus_wr, "R9", "stays idle", busy, 0);
    @(negedge clk);
    check(illegal == 0, "R9", "illegal one cycle", illegal, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !illegal, "R1", "idle after reset", busy, 0);
    check(!bus_rd && !bus_wr && !reg_wr && !flag_wr, "R1", "no strobes", bus_rd, 0);

    // R2 register forms, R6 inc/dec flags keep C
    run_reg(8'hBC, K_INC, 2'd0, 8'h7F, 1'b1, 2);
    run_reg(8'h3D, K_INC, 2'd1, 8'hFF, 1'b0, 6);
    run_reg(8'hFC, K_INC, 2'd2, 8'h41, 1'b1, 2);
    run_reg(8'h9C, K_DEC, 2'd0, 8'h00, 1'b1, 6);
    run_reg(8'h1D, K_DEC, 2'd1, 8'h01, 1'b0, 6);
    run_reg(8'hDC, K_DEC, 2'd2, 8'h90, 1'b0, 2);
    // R7 shifts
    run_reg(8'h1C, K_SHL, 2'd0, 8'h81, 1'b0, 7);
    run_reg(8'h5C, K_SHR, 2'd0, 8'h01, 1'b1, 7);
    // R8 rotates through carry
    run_reg(8'h3C, K_ROL, 2'd0, 8'h80, 1'b1, 8);
    run_reg(8'h7C, K_ROR, 2'd0, 8'h01, 1'b0, 8);
    run_reg(8'h7C, K_ROR, 2'd0, 8'h02, 1'b1, 8);

    // R3 direct page on both pages
    run_dp(8'hAB, K_INC, 1'b0, 8'h10, 8'h05, 1'b0, 0, 3);
    run_dp(8'h8B, K_DEC, 1'b1, 8'hF0, 8'h80, 1'b1, 0, 3);
    run_dp(8'h0B, K_SHL, 1'b0, 8'h3E, 8'hC0, 1'b0, 0, 7);
    run_dp(8'h4B, K_SHR, 1'b1, 8'h00, 8'hFE, 1'b1, 0, 7);
    run_dp(8'h2B, K_ROL, 1'b0, 8'h55, 8'h7F, 1'b1, 0, 8);
    // R10 start held high with a legal opcode while busy
    run_dp(8'h6B, K_ROR, 1'b1, 8'hAA, 8'h01, 1'b1, 1, 10);

    // R4 indexed direct page, including 8-bit wrap of offset+X
    run_dpx(8'hBB, K_INC, 1'b0, 8'hF0, 8'h20, 8'hFF, 1'b1, 4);
    run_dpx(8'h9B, K_DEC, 1'b1, 8'hFF, 8'h01, 8'h10, 1'b0, 4);
    run_dpx(8'h1B, K_SHL, 1'b0, 8'h04, 8'h03, 8'h40, 1'b1, 4);
    run_dpx(8'h5B, K_SHR, 1'b1, 8'h80, 8'h80, 8'h03, 1'b0, 4);
    run_dpx(8'h3B, K_ROL, 1'b0, 8'h12, 8'h00, 8'h00, 1'b1, 8);
    run_dpx(8'h7B, K_ROR, 1'b1, 8'h01, 8'hFE, 8'h00, 1'b0, 8);

    // R5 absolute, low byte then high byte
    run_abs(8'hAC, K_INC, 16'h1234, 16'hBEEF, 8'h0F, 1'b0, 5);
    run_abs(8'h8C, K_DEC, 16'h20FF, 16'h0102, 8'h01, 1'b1, 5);
    run_abs(8'h0C, K_SHL, 16'h4000, 16'hFF00, 8'h80, 1'b0, 5);
    run_abs(8'h4C, K_SHR, 16'h5555, 16'h00FF, 8'h81, 1'b0, 5);
    run_abs(8'h2C, K_ROL, 16'h7777, 16'hA5A5, 8'h00, 1'b1, 5);
    run_abs(8'h6C, K_ROR, 16'h0001, 16'h8000, 8'hFF, 1'b1, 5);

    // R9 unsupported opcodes
    run_bad(8'h00);
    run_bad(8'hFF);
    run_bad(8'hAD);
    run_reg(8'hBC, K_INC, 2'd0, 8'h00, 1'b0, 9);

    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule